// File: doc/BRIEF.md
# Programmable Clock Divider Bank

This block turns a set of source clocks into divided output clocks under register control. Each generator lane picks one of up to eight source clocks. It can invert that source, divide it by any ratio from 1 to 256, and drive the result out. The output can be inverted, or the divider can be skipped so the lane drives the undivided source. One shared control word sets the gating modes of two bus clocks, a global divider enable, and one input-inversion bit per lane. Every source clock is modelled as a level signal that is sampled by a single fast clock `clk`. A source edge is a rising level seen in that domain.

Software writes the control words through a simple word-addressed port. A write takes effect on the next `clk` edge, and a read returns data combinationally during the access. Changes to a lane's divide value and source select are staged. A lane applies them only when its current output period ends, so a reprogramming never shortens a pulse. The two clock-enable outputs tell the clock tree when the register bus clock and the peripheral bus clock may run.

Top module: `divclk_gen`

## Requirements
- R1: After reset every register reads 0, every `genClk` bit is 0, and `busClkEn` is 0.
- R2: Lane word n sits at address 2n. Its fields are bypass in bit 0, output invert in bit 1, source select in bits [4:2] and divide-minus-one in bits [12:5]. It reads back bits [12:0] as written and reads 0 above them. Odd addresses below the shared address read 0 and ignore writes. The shared word sits at address 2·NUM_GEN and reads back as written, except that a bus mode of 1 reads as 0.
- R3: The bus mode is held in shared bits [1:0]. Mode 3 holds `busClkEn` at 1. Mode 2 drives it with `regWrEn | regRdEn`. Modes 0 and 1 hold it at 0.
- R4: Shared bit 3 set to 1 holds `apbClkEn` at 1. When the bit is 0, `apbClkEn` follows `regWrEn | regRdEn`.
- R5: A divide field k with k ≥ 1 gives an output period of k+1 source periods. The output rises on the source edge that starts a period and stays high for floor((k+1)/2) source periods. An even ratio therefore gives a 50% duty cycle.
- R6: A divide field of 0 makes the divided output follow the selected source level, one `clk` later.
- R7: While shared bit 2 (divider enable) is 0, the divided output of every lane holds its value and the lane's counter does not advance.
- R8: A new divide value or source select is applied only on the source edge that ends the current output period.
- R9: Shared bit 4+n inverts the source level that lane n sees before it detects edges and before bypass.
- R10: Lane bit 1 inverts the lane output. Lane bit 0 drives the output from the selected source level, after input inversion, in place of the divided clock. Both bits act without delay.
- R11: The source select field picks which bit of `srcLvlIn` clocks the lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Word address of the access |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, combinational |
| srcLvlIn | input | NUM_SRC | Source clock levels |
| genClk | output | NUM_GEN | Lane output clocks |
| busClkEn | output | 1 | Register bus clock enable |
| apbClkEn | output | 1 | Peripheral bus clock enable |

## Verification
The hard case is a register write that lands in the same cycle as a lane's period boundary, or just before it. The bench reprograms a running lane's divide value and source at arbitrary points in the output period. It also rewrites the shared word while lanes are counting, so enable, inversion and bus-mode changes meet live source edges. A behavioural model stages the new configuration and applies it only at the boundary. The outputs are compared against that model on every clock. Any early or late application shows up as a mismatch on `genClk`.

// File: rtl/divclk_pkg.sv
package divclk_pkg;

  localparam int GEN_W   = 13;
  localparam int MAX_GEN = 8;
  localparam int SEL_W   = 3;
  localparam int DIV_W   = 8;

  // field order mirrors the lane word layout, bit 12 down to bit 0
  typedef struct packed {
    logic [DIV_W-1:0] divM1;
    logic [SEL_W-1:0] src;
    logic             outInv;
    logic             bypass;
  } genCfg_t;

  typedef enum logic [1:0] {
    BUS_OFF  = 2'd0,
    BUS_RSVD = 2'd1,
    BUS_DYN  = 2'd2,
    BUS_ON   = 2'd3
  } busMode_e;

  typedef struct packed {
    logic               divEn;
    logic [MAX_GEN-1:0] inInv;
  } pathCtl_t;

endpackage

// File: rtl/divclk_regs.sv
module divclk_regs
  import divclk_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic                       regWrEn,
  input  logic                       regRdEn,
  input  logic [DATA_W-1:0]          regWdata,
  output logic [DATA_W-1:0]          regRdata,
  output genCfg_t [NUM_GEN-1:0]      genCfg,
  output pathCtl_t                   pathCtl,
  output logic                       busClkEn,
  output logic                       apbClkEn
);

  localparam int SHARED_IDX = 2 * NUM_GEN;
  localparam int SHARED_W   = 4 + NUM_GEN;

  logic [SHARED_W-1:0] sharedQ;
  logic [SHARED_W-1:0] sharedRd;
  logic                sharedHit;
  logic                accessPending;
  busMode_e            busMode;

  assign sharedHit     = (regAddr == ADDR_W'(SHARED_IDX));
  assign accessPending = regWrEn | regRdEn;
  assign busMode       = busMode_e'(sharedQ[1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sharedQ <= '0;
    end else if (regWrEn && sharedHit) begin
      sharedQ <= regWdata[SHARED_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_laneReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        genCfg[g] <= '0;
      end else if (regWrEn && regAddr == ADDR_W'(2 * g)) begin
        genCfg[g] <= genCfg_t'(regWdata[GEN_W-1:0]);
      end
    end
  end

  // reserved bus code reads back as disabled
  always_comb begin
    sharedRd = sharedQ;
    if (busMode == BUS_RSVD) sharedRd[1:0] = 2'b00;
  end

  always_comb begin
    regRdata = '0;
    if (sharedHit) regRdata = DATA_W'(sharedRd);
    for (int g = 0; g < NUM_GEN; g++) begin
      if (regAddr == ADDR_W'(2 * g)) regRdata = DATA_W'(genCfg[g]);
    end
  end

  always_comb begin
    pathCtl       = '0;
    pathCtl.divEn = sharedQ[2];
    pathCtl.inInv = MAX_GEN'(sharedQ[SHARED_W-1:4]);
  end

  always_comb begin
    unique case (busMode)
      BUS_ON:  busClkEn = 1'b1;
      BUS_DYN: busClkEn = accessPending;
      default: busClkEn = 1'b0;
    endcase
  end

  assign apbClkEn = sharedQ[3] | accessPending;

endmodule

// File: rtl/divclk_lane.sv
module divclk_lane
  import divclk_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLvlIn,
  input  genCfg_t            cfg,
  input  logic               divEn,
  input  logic               inInv,
  output logic               genClk
);

  localparam int SRC_SPAN = 1 << SEL_W;

  logic [SRC_SPAN-1:0] srcPad;
  logic [SEL_W-1:0]    actSrc;
  logic [DIV_W-1:0]    actDiv;
  logic [DIV_W-1:0]    cnt;
  logic [DIV_W-1:0]    nCnt;
  logic [DIV_W-1:0]    nDiv;
  logic [DIV_W:0]      halfN;
  logic                lvl;
  logic                lvlQ;
  logic                srcEdge;
  logic                wrap;
  logic                divOut;

  always_comb begin
    srcPad                = '0;
    srcPad[NUM_SRC-1:0]   = srcLvlIn;
  end

  assign lvl     = srcPad[actSrc] ^ inInv;
  assign srcEdge = lvl & ~lvlQ;
  assign wrap    = (cnt == actDiv);
  assign nDiv    = wrap ? cfg.divM1 : actDiv;
  assign nCnt    = wrap ? '0 : cnt + DIV_W'(1);
  assign halfN   = ({1'b0, nDiv} + (DIV_W+1)'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlQ   <= 1'b0;
      cnt    <= '0;
      actDiv <= '0;
      actSrc <= '0;
      divOut <= 1'b0;
    end else begin
      lvlQ <= lvl;
      if (divEn) begin
        if (srcEdge) begin
          cnt <= nCnt;
          if (wrap) begin
            actDiv <= cfg.divM1;
            actSrc <= cfg.src;
          end
          divOut <= (nDiv == '0) ? 1'b1 : ({1'b0, nCnt} < halfN);
        end else if (actDiv == '0) begin
          divOut <= lvl;
        end
      end
    end
  end

  assign genClk = (cfg.bypass ? lvl : divOut) ^ cfg.outInv;

endmodule

// File: rtl/divclk_path.sv
module divclk_path
  import divclk_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int NUM_SRC = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    srcLvlIn,
  input  genCfg_t [NUM_GEN-1:0] genCfg,
  input  pathCtl_t              pathCtl,
  output logic [NUM_GEN-1:0]    genClk
);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_lane
    divclk_lane #(.NUM_SRC(NUM_SRC)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .srcLvlIn (srcLvlIn),
      .cfg      (genCfg[g]),
      .divEn    (pathCtl.divEn),
      .inInv    (pathCtl.inInv[g]),
      .genClk   (genClk[g])
    );
  end

endmodule

// File: rtl/divclk_gen.sv
module divclk_gen
  import divclk_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = $clog2(2 * NUM_GEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] srcLvlIn,
  output logic [NUM_GEN-1:0] genClk,
  output logic               busClkEn,
  output logic               apbClkEn
);

  genCfg_t [NUM_GEN-1:0] genCfg;
  pathCtl_t              pathCtl;

  divclk_regs #(
    .NUM_GEN (NUM_GEN),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .genCfg   (genCfg),
    .pathCtl  (pathCtl),
    .busClkEn (busClkEn),
    .apbClkEn (apbClkEn)
  );

  divclk_path #(
    .NUM_GEN (NUM_GEN),
    .NUM_SRC (NUM_SRC)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .srcLvlIn (srcLvlIn),
    .genCfg   (genCfg),
    .pathCtl  (pathCtl),
    .genClk   (genClk)
  );

endmodule

// File: rtl/divclk_gen_chk.sv
module divclk_gen_chk
  import divclk_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     regAddr,
  input logic                  regWrEn,
  input logic                  regRdEn,
  input logic [DATA_W-1:0]     regWdata,
  input logic [DATA_W-1:0]     regRdata,
  input logic [NUM_GEN-1:0]    genClk,
  input logic                  busClkEn,
  input logic                  apbClkEn,
  input logic                  divEn,
  input genCfg_t [NUM_GEN-1:0] genCfg
);

  localparam int SHARED_IDX = 2 * NUM_GEN;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (genClk == '0 && !busClkEn));

  assert_bus_always_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(SHARED_IDX) && regWdata[1:0] == 2'b11)
      |=> busClkEn);

  assert_apb_always_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(SHARED_IDX) && regWdata[3]) |=> apbClkEn);

  assert_rsvd_mode_hidden_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(SHARED_IDX)) |-> regRdata[1:0] != 2'b01);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    assert_odd_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
      (regRdEn && regAddr == ADDR_W'(2 * g + 1)) |-> regRdata == '0);

    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(divEn) && !genCfg[g].bypass && !$past(genCfg[g].bypass)
        && $stable(genCfg[g].outInv)) |-> $stable(genClk[g]));
  end

endmodule

bind divclk_gen divclk_gen_chk #(
  .NUM_GEN (NUM_GEN),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .genClk   (genClk),
  .busClkEn (busClkEn),
  .apbClkEn (apbClkEn),
  .divEn    (pathCtl.divEn),
  .genCfg   (genCfg)
);

// File: tb/divclk_gen_tb.sv
module divclk_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_GEN    = 2;
  localparam int NUM_SRC    = 8;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 3;
  localparam int SH         = 2 * NUM_GEN;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [ADDR_W-1:0]  regAddr = '0;
  logic               regWrEn = 1'b0;
  logic               regRdEn = 1'b0;
  logic [DATA_W-1:0]  regWdata = '0;
  logic [DATA_W-1:0]  regRdata;
  logic [NUM_SRC-1:0] srcLvlIn = '0;
  logic [NUM_GEN-1:0] genClk;
  logic               busClkEn;
  logic               apbClkEn;

  int    checks = 0;
  int    fails = 0;
  int    cycleNo = 0;
  string curReq = "R1";

  // reference model state
  int mShared = 0;
  int mGen[NUM_GEN];
  int mCnt[NUM_GEN];
  int mActDiv[NUM_GEN];
  int mActSrc[NUM_GEN];
  int mDivOut[NUM_GEN];
  int mPrev[NUM_GEN];

  always #(CLK_PERIOD/2) clk = ~clk;

  divclk_gen #(.NUM_GEN(NUM_GEN), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWdata(regWdata), .regRdata(regRdata),
    .srcLvlIn(srcLvlIn), .genClk(genClk), .busClkEn(busClkEn),
    .apbClkEn(apbClkEn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycleNo);
    end
  endtask

  function automatic int modelLvl(int g);
    return ((int'(srcLvlIn) >> mActSrc[g]) & 1) ^ ((mShared >> (4 + g)) & 1);
  endfunction

  function automatic int modelRead(int a);
    if (a == SH) return ((mShared & 3) == 1) ? (mShared & ~3) : mShared;
    if (a < SH && a % 2 == 0) return mGen[a/2];
    return 0;
  endfunction

  task automatic modelReset();
    mShared = 0;
    for (int g = 0; g < NUM_GEN; g++) begin
      mGen[g] = 0; mCnt[g] = 0; mActDiv[g] = 0; mActSrc[g] = 0;
      mDivOut[g] = 0; mPrev[g] = 0;
    end
  endtask

  task automatic modelStep();
    int pend;
    pend = int'(regWrEn | regRdEn);
    for (int g = 0; g < NUM_GEN; g++) begin
      int lvl, nDiv;
      lvl = modelLvl(g);
      if ((mShared >> 2) & 1) begin
        if (lvl == 1 && mPrev[g] == 0) begin
          if (mCnt[g] == mActDiv[g]) begin
            mCnt[g] = 0;
            mActDiv[g] = (mGen[g] >> 5) & 255;
            mActSrc[g] = (mGen[g] >> 2) & 7;
          end else begin
            mCnt[g]++;
          end
          nDiv = mActDiv[g];
          mDivOut[g] = (nDiv == 0) ? 1 : int'(mCnt[g] < (nDiv + 1) / 2);
        end else if (mActDiv[g] == 0) begin
          mDivOut[g] = lvl;
        end
      end
      mPrev[g] = lvl;
    end
    if (regWrEn) begin
      if (regAddr == SH) mShared = int'(regWdata) & ((1 << (4 + NUM_GEN)) - 1);
      else if (regAddr < SH && regAddr % 2 == 0) mGen[regAddr/2] = int'(regWdata) & 16'h1FFF;
    end
    if (pend < 0) mShared = 0;
  endtask

  // one cycle: inputs already applied just after a falling edge
  task automatic step();
    int mode, expBus, expApb, pend;
    for (int k = 0; k < NUM_SRC; k++) srcLvlIn[k] = ((cycleNo / (k + 1)) % 2) == 1;
    #1;
    pend = int'(regWrEn | regRdEn);
    for (int g = 0; g < NUM_GEN; g++) begin
      int e;
      e = (((mGen[g] & 1) != 0) ? modelLvl(g) : mDivOut[g]) ^ ((mGen[g] >> 1) & 1);
      chk(int'(genClk[g]) == e, curReq, int'(genClk[g]), e);
    end
    mode = mShared & 3;
    expBus = (mode == 3) ? 1 : (mode == 2) ? pend : 0;
    chk(int'(busClkEn) == expBus, "R3", int'(busClkEn), expBus);
    expApb = ((mShared >> 3) & 1) | pend;
    chk(int'(apbClkEn) == expApb, "R4", int'(apbClkEn), expApb);
    if (regRdEn) chk(int'(regRdata) == modelRead(int'(regAddr)), curReq,
                     int'(regRdata), modelRead(int'(regAddr)));
    @(posedge clk);
    modelStep();
    @(negedge clk);
    cycleNo++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input int a, input int d);
    regAddr = ADDR_W'(a); regWdata = DATA_W'(d); regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a);
    regAddr = ADDR_W'(a); regRdEn = 1'b1;
    step();
    regRdEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hold;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    curReq = "R1";
    chk(genClk == '0, "R1", int'(genClk), 0);
    chk(!busClkEn, "R1", int'(busClkEn), 0);
    for (int a = 0; a <= SH; a++) rd(a);

    // R2: readback, odd holes, reserved bus code
    curReq = "R2";
    wr(0, 32'hFFFF_FFFF); rd(0);
    wr(2, 32'h0000_0ABC); rd(2);
    wr(1, 32'h55); rd(1);
    wr(3, 32'h7F); rd(3);
    wr(SH, 32'h35); rd(SH);
    wr(0, 0); wr(2, 0); wr(SH, 0); rd(SH);

    // R3 / R4: gating modes
    curReq = "R3";
    wr(SH, 32'h2); idle(3); rd(0); idle(2);
    wr(SH, 32'h3); idle(3);
    wr(SH, 32'h1); idle(2); rd(1);
    curReq = "R4";
    wr(SH, 32'h8); idle(3);
    wr(SH, 32'h0); rd(0); idle(2);

    // R5: even and odd ratios
    curReq = "R5";
    wr(0, 3 << 5); wr(SH, 32'h4); idle(40);
    wr(0, 4 << 5); idle(60);
    wr(0, (1 << 5) | (1 << 2)); idle(40);

    // R8: change mid-period, including a source change
    curReq = "R8";
    wr(0, (7 << 5) | (2 << 2)); idle(3);
    wr(0, (2 << 5) | (2 << 2)); idle(70);

    // R6: divide by one follows the source
    curReq = "R6";
    wr(0, 0); idle(40);
    wr(0, 5 << 5); idle(40);

    // R7: disable freezes divided output
    curReq = "R7";
    wr(SH, 32'h0);
    hold = int'(genClk[0]);
    idle(30);
    chk(int'(genClk[0]) == hold, "R7", int'(genClk[0]), hold);
    wr(SH, 32'h4); idle(20);

    // R9: input inversion per lane
    curReq = "R9";
    wr(SH, 32'h14); idle(30);
    wr(2, (2 << 5) | (3 << 2)); wr(SH, 32'h24); idle(50);

    // R10: output inversion and bypass
    curReq = "R10";
    wr(0, 32'h2 | (5 << 5)); idle(30);
    wr(0, 32'h1 | (2 << 2)); idle(20);
    wr(0, 32'h3 | (2 << 2)); idle(20);

    // R11: other source selections
    curReq = "R11";
    wr(0, (5 << 2) | (1 << 5)); idle(50);
    wr(0, (7 << 2) | (1 << 5)); wr(2, 6 << 2); idle(60);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule